// File: doc/BRIEF.md
# Multiplexed LED Matrix Scanner with Column Blink

This block holds the lamp pattern for a 26-row by 16-column LED pick-light matrix and drives it one column at a time. A command parser feeds it single-cycle write operations: clear everything, switch one LED on or off, enable or disable blinking for one column, and enter test mode. A clock prescaler inside the block sets the length of each column slot. Sixteen slots make one frame.

Each column is stored as one 32-bit word. Three bytes hold rows 0 to 23. The top byte holds row 25 in bit 31, row 24 in bit 30, and the column's blink enable in bit 24. A frame counter toggles a shared blink phase. While that phase is in its off half, columns whose blink bit is set are blanked. Columns without the bit are never blanked.

The pattern shown for a column is captured at the start of its slot. A write therefore never changes the column being shown, and it appears the next time its column is scanned. The first cycle of every slot drives no column and no rows, so that one column's rows cannot ghost into the next.

Top module: `led_scan_top`

## Requirements
- R1: After reset release the first cycle has col_en_o and row_o at zero. Column 0 is then shown with all rows off, the blink phase is on and test mode is off.
- R2: col_en_o is zero or one-hot. Each slot lasts CLK_DIV cycles. The driven column goes 0, 1, …, 15 and then wraps to 0.
- R3: In the first cycle of every slot, col_en_o and row_o are both zero. In every other cycle col_en_o has exactly one bit set.
- R4: Op 2 (LED on) and op 3 (LED off) set or clear the LED at column wr_col_i and row wr_row_i. Row r (0 = A … 25 = Z) appears on row_o[r].
- R5: The rows shown during a slot are fixed at the slot's start, so a write never changes row_o in the middle of a slot. A write made on or before the cycle that ends the previous slot is visible when its column is next shown.
- R6: Op 4 sets and op 5 clears the blink enable of column wr_col_i. The blink phase toggles after every BLINK_FRAMES full frames. While the phase is off, columns with blink enabled show all rows low and other columns are unaffected.
- R7: Op 1 (clear all) turns off every LED, clears every blink enable and leaves test mode.
- R8: Op 6 enters test mode. In test mode every row is driven high for each column in turn, whatever the stored pattern and blink state. Only op 1 leaves test mode; LED and blink writes made during test mode are still stored.
- R9: Op codes 0 and 7 have no effect. LED on and LED off with wr_row_i of 26 or more have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write operation strobe, one cycle per operation |
| wr_op_i | input | 3 | Operation code: 1 clear, 2 LED on, 3 LED off, 4 blink on, 5 blink off, 6 test |
| wr_col_i | input | 4 | Target column 0..15 |
| wr_row_i | input | 5 | Target row 0..25 |
| col_en_o | output | 16 | One-hot column sink enable |
| row_o | output | 26 | Row drive, bit r is row r |

## Verification
A corrupted column word shows up as a wrong row_o bit during that column's next lit slot, which is at most one frame (16·CLK_DIV cycles) later. A prescaler or column counter fault shows up as a wrong one-hot position or a missing blank cycle within one slot. A frame counter that is off by one moves the edge where blinking columns go dark by a whole frame. A test-mode flag that is lost or stuck changes every row of the next slot. The bench compares both outputs against its reference model on every cycle, so each of these faults is reported in the cycle where it first reaches the pins.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int NUM_COLS  = 16;
  localparam int NUM_ROWS  = 26;
  localparam int COL_W     = $clog2(NUM_COLS);
  localparam int ROW_W     = 5;
  localparam int WORD_W    = 32;
  localparam int BITIDX_W  = $clog2(WORD_W);
  localparam int BLINK_BIT = 24;
  localparam int LOW_ROWS  = 24;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_CLEAR   = 3'd1,
    OP_LED_ON  = 3'd2,
    OP_LED_OFF = 3'd3,
    OP_BLK_ON  = 3'd4,
    OP_BLK_OFF = 3'd5,
    OP_TEST    = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  // row 0..23 -> bits 0..23, row 24 -> bit 30, row 25 -> bit 31
  function automatic logic [BITIDX_W-1:0] row_bit(logic [ROW_W-1:0] r);
    if (r < ROW_W'(LOW_ROWS)) return BITIDX_W'(r);
    else if (r == ROW_W'(LOW_ROWS)) return BITIDX_W'(30);
    else return BITIDX_W'(31);
  endfunction

  function automatic logic [NUM_ROWS-1:0] word_rows(logic [WORD_W-1:0] w);
    return {w[31], w[30], w[LOW_ROWS-1:0]};
  endfunction
endpackage

// File: rtl/led_scan_prescaler.sv
module led_scan_prescaler #(
  parameter int CLK_DIV = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic first_o
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o  = (cnt_q == LAST);
  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
#(
  parameter int BLINK_FRAMES = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] col_nxt_o,
  output logic             phase_nxt_o
);
  localparam int FR_W = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;
  localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(BLINK_FRAMES - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  logic [COL_W-1:0] col_q;
  logic [FR_W-1:0]  frame_q, frame_d;
  logic             phase_q, phase_d;
  logic             wrap;

  assign wrap = tick_i && (col_q == COL_LAST);

  always_comb begin
    col_nxt_o = col_q;
    frame_d   = frame_q;
    phase_d   = phase_q;
    if (tick_i) col_nxt_o = (col_q == COL_LAST) ? '0 : col_q + 1'b1;
    if (wrap) begin
      if (frame_q == FR_LAST) begin
        frame_d = '0;
        phase_d = ~phase_q;
      end else begin
        frame_d = frame_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      frame_q <= '0;
      phase_q <= 1'b1;
    end else begin
      col_q   <= col_nxt_o;
      frame_q <= frame_d;
      phase_q <= phase_d;
    end
  end

  assign col_o       = col_q;
  assign phase_nxt_o = phase_d;
endmodule

// File: rtl/led_col_store.sv
module led_col_store
  import led_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [2:0]        wr_op_i,
  input  logic [COL_W-1:0]  wr_col_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam logic [WORD_W-1:0] BLK_MASK = WORD_W'(1) << BLINK_BIT;

  op_e               op;
  logic              row_ok;
  logic [WORD_W-1:0] led_mask;
  logic [WORD_W-1:0] word_nx [NUM_COLS];

  assign op       = op_e'(wr_op_i);
  assign row_ok   = (wr_row_i < ROW_W'(NUM_ROWS));
  assign led_mask = WORD_W'(1) << row_bit(wr_row_i);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [WORD_W-1:0] w_q, w_d;
    logic              hit;

    assign hit = wr_valid_i && (wr_col_i == COL_W'(c));

    always_comb begin
      w_d = w_q;
      if (wr_valid_i && op == OP_CLEAR) w_d = '0;
      else if (hit) begin
        case (op)
          OP_LED_ON:  if (row_ok) w_d = w_q | led_mask;
          OP_LED_OFF: if (row_ok) w_d = w_q & ~led_mask;
          OP_BLK_ON:  w_d = w_q | BLK_MASK;
          OP_BLK_OFF: w_d = w_q & ~BLK_MASK;
          default:    w_d = w_q;
        endcase
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w_q <= '0;
      else         w_q <= w_d;
    end

    // forward the post-write value so a same-cycle write is not missed
    assign word_nx[c] = w_d;
  end

  assign rd_word_o = word_nx[rd_col_i];
endmodule

// File: rtl/led_row_drive.sv
module led_row_drive
  import led_scan_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [2:0]          wr_op_i,
  input  logic                load_i,
  input  logic                first_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                phase_nxt_i,
  output logic                test_o,
  output logic [NUM_COLS-1:0] col_en_o,
  output logic [NUM_ROWS-1:0] row_o
);
  op_e                op;
  logic               test_q, test_d;
  logic [NUM_ROWS-1:0] disp_q, disp_d;

  assign op = op_e'(wr_op_i);

  always_comb begin
    test_d = test_q;
    if (wr_valid_i && op == OP_CLEAR)     test_d = 1'b0;
    else if (wr_valid_i && op == OP_TEST) test_d = 1'b1;
  end

  always_comb begin
    if (test_d)                                disp_d = '1;
    else if (word_i[BLINK_BIT] && !phase_nxt_i) disp_d = '0;
    else                                       disp_d = word_rows(word_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q <= 1'b0;
      disp_q <= '0;
    end else begin
      test_q <= test_d;
      if (load_i) disp_q <= disp_d;
    end
  end

  assign test_o   = test_q;
  assign col_en_o = first_i ? '0 : (NUM_COLS'(1) << col_i);
  assign row_o    = first_i ? '0 : disp_q;
endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
  import led_scan_pkg::*;
#(
  parameter int CLK_DIV      = 1024,
  parameter int BLINK_FRAMES = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [2:0]          wr_op_i,
  input  logic [COL_W-1:0]    wr_col_i,
  input  logic [ROW_W-1:0]    wr_row_i,
  output logic [NUM_COLS-1:0] col_en_o,
  output logic [NUM_ROWS-1:0] row_o
);
  logic              tick, first;
  logic [COL_W-1:0]  col, col_nxt;
  logic              phase_nxt;
  logic [WORD_W-1:0] word_nxt;
  logic              test_mode;

  led_scan_prescaler #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk_i, .rst_ni, .tick_o(tick), .first_o(first)
  );

  led_scan_seq #(.BLINK_FRAMES(BLINK_FRAMES)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick),
    .col_o(col), .col_nxt_o(col_nxt), .phase_nxt_o(phase_nxt)
  );

  led_col_store u_store (
    .clk_i, .rst_ni, .wr_valid_i, .wr_op_i, .wr_col_i, .wr_row_i,
    .rd_col_i(col_nxt), .rd_word_o(word_nxt)
  );

  led_row_drive u_drive (
    .clk_i, .rst_ni, .wr_valid_i, .wr_op_i,
    .load_i(tick), .first_i(first), .col_i(col),
    .word_i(word_nxt), .phase_nxt_i(phase_nxt),
    .test_o(test_mode), .col_en_o, .row_o
  );
endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk
  import led_scan_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_valid_i,
  input logic [2:0]          wr_op_i,
  input logic [NUM_COLS-1:0] col_en_o,
  input logic [NUM_ROWS-1:0] row_o,
  input logic                test_i
);
  AST_COL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(col_en_o)); // R2

  AST_BLANK_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|col_en_o) && (|$past(col_en_o))) |-> (col_en_o == $past(col_en_o))); // R3

  AST_ROWS_NEED_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|row_o) |-> (|col_en_o)); // R3

  AST_ROWS_HOLD_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|col_en_o) && (col_en_o == $past(col_en_o))) |-> $stable(row_o)); // R5

  AST_TEST_ALL_ROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|col_en_o) && !(|$past(col_en_o)) && $past(test_i)) |-> (&row_o)); // R8

  AST_TEST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && !(wr_valid_i && wr_op_i == 3'd1)) |=> test_i); // R8

  AST_CLEAR_DROPS_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_op_i == 3'd1) |=> !test_i); // R7
endmodule

bind led_scan_top led_scan_chk u_chk (
  .clk_i, .rst_ni, .wr_valid_i, .wr_op_i, .col_en_o, .row_o,
  .test_i(test_mode)
);

// File: tb/tb_led_scan_top.sv
module tb_led_scan_top;
  localparam int DIV = 8;
  localparam int BF  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_op = 3'd0;
  logic [3:0]  wr_col = 4'd0;
  logic [4:0]  wr_row = 5'd0;
  logic [15:0] col_en;
  logic [25:0] row;

  led_scan_top #(.CLK_DIV(DIV), .BLINK_FRAMES(BF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_op_i(wr_op),
    .wr_col_i(wr_col), .wr_row_i(wr_row), .col_en_o(col_en), .row_o(row)
  );

  always #2 clk = ~clk;

  // reference model state
  bit          led [16][26];
  bit          blk [16];
  bit          m_test, m_phase;
  int          m_pre, m_col, m_frame;
  logic [25:0] m_snap;
  int          vectors = 0, errors = 0;
  string       cur_req = "R1";
  bit          done = 1'b0;

  function automatic logic [25:0] col_rows(int c);
    logic [25:0] v;
    for (int r = 0; r < 26; r++) v[r] = led[c][r];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 16; c++) begin
        blk[c] = 1'b0;
        for (int r = 0; r < 26; r++) led[c][r] = 1'b0;
      end
      m_test = 0; m_phase = 1; m_pre = 0; m_col = 0; m_frame = 0; m_snap = '0;
    end else begin
      if (wr_valid) begin
        case (wr_op)
          3'd1: begin
            m_test = 0;
            for (int c = 0; c < 16; c++) begin
              blk[c] = 0;
              for (int r = 0; r < 26; r++) led[c][r] = 0;
            end
          end
          3'd2: if (wr_row < 26) led[wr_col][wr_row] = 1;
          3'd3: if (wr_row < 26) led[wr_col][wr_row] = 0;
          3'd4: blk[wr_col] = 1;
          3'd5: blk[wr_col] = 0;
          3'd6: m_test = 1;
          default: ;
        endcase
      end
      if (m_pre == DIV - 1) begin
        m_pre = 0;
        m_col = (m_col + 1) % 16;
        if (m_col == 0) begin
          m_frame++;
          if (m_frame == BF) begin m_frame = 0; m_phase = !m_phase; end
        end
        if (m_test) m_snap = '1;
        else if (blk[m_col] && !m_phase) m_snap = '0;
        else m_snap = col_rows(m_col);
      end else m_pre++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] ec;
      logic [25:0] er;
      ec = (m_pre == 0) ? 16'd0 : (16'd1 << m_col);
      er = (m_pre == 0) ? 26'd0 : m_snap;
      vectors++;
      if (col_en !== ec || row !== er) begin
        errors++;
        $display("FAIL %s t=%0t col_en=%h exp %h row=%h exp %h",
                 cur_req, $time, col_en, ec, row, er);
      end
    end
  end

  task automatic wr(input logic [2:0] op, input int c, input int r);
    @(negedge clk);
    wr_valid = 1'b1; wr_op = op; wr_col = 4'(c); wr_row = 5'(r);
    @(negedge clk);
    wr_valid = 1'b0; wr_op = 3'd0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; run(140);
    cur_req = "R2"; run(130);
    cur_req = "R3"; run(130);
    cur_req = "R4";
    wr(3'd2, 0, 0); wr(3'd2, 0, 7); wr(3'd2, 5, 8); wr(3'd2, 5, 23);
    wr(3'd2, 15, 24); wr(3'd2, 15, 25); wr(3'd2, 3, 12);
    run(150);
    wr(3'd3, 0, 7); run(150);
    cur_req = "R5";
    for (int i = 0; i < 24; i++) begin
      wr(3'd2, (i * 5) % 16, (i * 7) % 26);
      run(i % 5);
      wr(3'd3, (i * 3) % 16, (i * 11) % 26);
    end
    run(150);
    cur_req = "R6";
    wr(3'd4, 5, 0); wr(3'd4, 15, 0); run(600);
    wr(3'd5, 15, 0); run(300);
    cur_req = "R9";
    wr(3'd0, 4, 4); wr(3'd7, 6, 6); wr(3'd2, 2, 26); wr(3'd2, 9, 31);
    wr(3'd3, 5, 29); run(150);
    cur_req = "R8";
    wr(3'd6, 0, 0); run(150);
    wr(3'd3, 5, 8); wr(3'd2, 10, 1); wr(3'd4, 10, 0); wr(3'd0, 0, 0); run(400);
    cur_req = "R7";
    wr(3'd1, 0, 0); run(300);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule